// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block programs a single byte of a flash array on behalf of a host that only has to issue two commands. First a set-up strobe arms the block. The very next command must be a program strobe, and that strobe carries the target address and data. The sequencer then runs the whole write on its own. It drives a programming pulse of a fixed width, reads the byte back and compares it with the intended value. On a mismatch it repeats the pulse-and-verify pass until the byte matches or the pass limit is used up.

The host follows progress by polling. While an operation runs, the status byte shows the inverse of the target's top bit. When the operation ends, the status byte shows the last byte read back. A sticky failure flag reports an operation that ran out of passes, and only a reset command clears it. Command strobes arrive already decoded. Capturing them from a bus is not part of this block, and neither are the analog side and erase.

Top module: `flash_prog_seq`

## Requirements
- R1: An operation starts only when `cmd_program` is the first command strobe after `cmd_setup`. Idle cycles between the two are allowed. A program strobe with no preceding set-up, or one preceded by any other strobe, leaves `busy` low and drives no pulse.
- R2: Each pass holds `arr_pulse` high for exactly `PULSE_CYCLES` consecutive clocks. During the pulse, `arr_addr` and `arr_wdata` hold the target address and data.
- R3: The clock after a pulse ends, `arr_rd` is high for one cycle. `arr_rdata` is compared one clock later, so a pass lasts `PULSE_CYCLES + 2` clocks.
- R4: When the read-back matches after pass k, `busy` falls k*(`PULSE_CYCLES`+2) clocks after the edge that sampled the program strobe.
- R5: After `MAX_PASSES` (25) passes with no match, the operation stops with `fail` high, having issued exactly 25 pulses.
- R6: While `busy` is high, `poll_data` equals {~data[7], 7'b0}, where data is the target data.
- R7: Once an operation ends, `poll_data` equals the last byte read back. This is the target data on success.
- R8: Every command strobe that arrives while `busy` is high is ignored. This covers set-up, program and reset.
- R9: `fail` stays high until a `cmd_reset` is accepted while idle. It survives later operations, including ones that pass.
- R10: After reset, `busy`, `fail`, `arr_pulse` and `arr_rd` are low and `poll_data` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_setup | input | 1 | Program set-up command strobe |
| cmd_program | input | 1 | Program command strobe |
| cmd_reset | input | 1 | Reset command strobe; clears the failure flag |
| cmd_addr | input | ADDR_W | Target address, sampled with cmd_program |
| cmd_data | input | 8 | Target data, sampled with cmd_program |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 8 | Array program data |
| arr_pulse | output | 1 | Programming pulse strobe |
| arr_rd | output | 1 | Array read strobe |
| arr_rdata | input | 8 | Array read data, valid one clock after arr_rd |
| busy | output | 1 | Operation in progress |
| fail | output | 1 | Sticky failure flag |
| poll_data | output | 8 | Polled status / result byte |

## Verification
The program strobe is driven half a clock before the edge that samples it. `busy` is then expected high at the next falling edge, and from that point the bench counts falling edges until `busy` drops. The count must equal the number of passes the array model needs, capped at 25, times `PULSE_CYCLES`+2. The array model returns read data one clock after `arr_rd`. It counts pulse rising edges and pulse lengths at rising clock edges, and the bench compares those counts against the expected pass count once the operation is over. Results for `poll_data` and `fail` are sampled at the first falling edge with `busy` low. Ignored strobes are checked one falling edge after they are driven.

// File: rtl/flash_prog_pkg.sv
// Package: shared types for the flash byte program sequencer.
// Assumes: data bytes are 8 bits wide.
package flash_prog_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_READ  = 2'd2,
        ST_CMP   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fps_cmd_arm.sv
// Module: tracks the two-step command handshake.
// A set-up strobe arms the block. Any other strobe disarms it.
// A program strobe seen while armed produces a one-cycle start.
// Assumes: at most one strobe per cycle; all strobes are dropped while busy.
module fps_cmd_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic cmd_setup,
    input  logic cmd_program,
    input  logic cmd_reset,
    output logic start,
    output logic clr_fail
);
    logic armed_q;
    logic any_cmd;

    // Any strobe counts as the next command while idle.
    assign any_cmd  = cmd_setup | cmd_program | cmd_reset;
    assign start    = cmd_program & armed_q & ~busy;
    assign clr_fail = cmd_reset & ~busy;

    // Arm on set-up; clear on any other accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!busy && any_cmd) begin
            armed_q <= cmd_setup;
        end
    end
endmodule

// File: rtl/fps_pulse_timer.sv
// Module: times the programming pulse in clock cycles.
// done is high in the last cycle of a pulse of PULSE_CYCLES clocks.
// Assumes: run stays high from the first pulse cycle through done.
module fps_pulse_timer #(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    // Count pulse cycles; hold at zero outside a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fps_pass_counter.sv
// Module: counts failed pulse-and-verify passes of one operation.
// last is high while the current pass is the final one allowed.
// Assumes: clr is pulsed at operation start; inc only on a mismatch.
module fps_pass_counter #(
    parameter int MAX_PASSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_PASSES + 1);
    localparam logic [CW-1:0] FINAL = CW'(MAX_PASSES - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == FINAL);

    // Restart at operation start, advance once per failed pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/flash_prog_seq.sv
// Module: top of the flash byte program sequencer.
// Sequence: PULSE (PULSE_CYCLES clocks), then READ (1 clock), then
// CMP (1 clock). CMP either finishes the operation or starts a new pass.
// Assumes: the array read port returns data one clock after arr_rd.
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int PULSE_CYCLES = 8,
    parameter int MAX_PASSES   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_setup,
    input  logic              cmd_program,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              arr_pulse,
    output logic              arr_rd,
    input  logic [7:0]        arr_rdata,
    output logic              busy,
    output logic              fail,
    output logic [7:0]        poll_data
);
    localparam byte_t ERASED = 8'hFF;

    seq_state_t        state_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    byte_t             tgt_data_q;
    byte_t             result_q;
    logic              fail_q;
    logic              start;
    logic              clr_fail;
    logic              tmr_done;
    logic              last_pass;
    logic              match;
    logic              mismatch;

    assign busy      = (state_q != ST_IDLE);
    assign arr_pulse = (state_q == ST_PULSE);
    assign arr_rd    = (state_q == ST_READ);
    assign arr_addr  = tgt_addr_q;
    assign arr_wdata = tgt_data_q;
    assign fail      = fail_q;
    assign match     = (state_q == ST_CMP) && (arr_rdata == tgt_data_q);
    assign mismatch  = (state_q == ST_CMP) && (arr_rdata != tgt_data_q);
    assign poll_data = busy ? {~tgt_data_q[7], 7'b0} : result_q;

    fps_cmd_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .cmd_setup   (cmd_setup),
        .cmd_program (cmd_program),
        .cmd_reset   (cmd_reset),
        .start       (start),
        .clr_fail    (clr_fail)
    );

    fps_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (arr_pulse),
        .done  (tmr_done)
    );

    fps_pass_counter #(.MAX_PASSES(MAX_PASSES)) u_passes (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (mismatch),
        .last  (last_pass)
    );

    // Main sequence: latch the target, pulse, read, compare, loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            result_q   <= ERASED;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tgt_addr_q <= cmd_addr;
                        tgt_data_q <= cmd_data;
                        state_q    <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (tmr_done) state_q <= ST_READ;
                end
                ST_READ: begin
                    state_q <= ST_CMP;
                end
                ST_CMP: begin
                    if (match || last_pass) begin
                        result_q <= arr_rdata;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q  <= ST_PULSE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky failure flag: set when passes run out, cleared by reset command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (mismatch && last_pass) begin
            fail_q <= 1'b1;
        end else if (clr_fail) begin
            fail_q <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_prog_seq_chk.sv
// Checker: temporal properties of the flash byte program sequencer.
// Attached to every flash_prog_seq instance by the bind below.
module flash_prog_seq_chk #(
    parameter int ADDR_W       = 4,
    parameter int PULSE_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_program,
    input logic              cmd_reset,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        arr_wdata,
    input logic              arr_pulse,
    input logic              arr_rd,
    input logic              busy,
    input logic              fail,
    input logic [7:0]        poll_data
);
    int unsigned run_len;

    // Length of the current pulse run, in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else        run_len <= arr_pulse ? run_len + 1 : 0;
    end

    p_start_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_program));

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_pulse) |-> (run_len == PULSE_CYCLES));

    p_pulse_not_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pulse |-> (run_len < PULSE_CYCLES));

    p_target_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pulse && $past(arr_pulse)) |-> ($stable(arr_addr) && $stable(arr_wdata)));

    p_read_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_pulse) |-> arr_rd);

    p_read_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |=> !arr_rd && !arr_pulse);

    p_strobes_need_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pulse || arr_rd) |-> busy);

    p_poll_inverted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (poll_data == {~arr_wdata[7], 7'b0}));

    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !cmd_reset) |=> fail);

    p_fail_kept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && busy) |=> fail);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W       (ADDR_W),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_program (cmd_program),
    .cmd_reset   (cmd_reset),
    .arr_addr    (arr_addr),
    .arr_wdata   (arr_wdata),
    .arr_pulse   (arr_pulse),
    .arr_rd      (arr_rd),
    .busy        (busy),
    .fail        (fail),
    .poll_data   (poll_data)
);

// File: tb/flash_prog_seq_test.sv
// Bench: directed corner cases plus seeded random operations against an
// array model that needs a chosen number of pulses before a byte reads back.
module flash_prog_seq_test;
    localparam int AW   = 4;
    localparam int PW   = 8;
    localparam int MAXP = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_setup = 1'b0, cmd_program = 1'b0, cmd_reset = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;
    logic          arr_pulse, arr_rd;
    logic [7:0]    arr_rdata = 8'h00;
    logic          busy, fail;
    logic [7:0]    poll_data;

    int n_tests = 0;
    int n_fail  = 0;
    int need    = 1;
    int pulses_seen = 0;
    int bad_width = 0;
    int run_len = 0;
    logic pulse_prev = 1'b0;
    bit done = 1'b0;

    flash_prog_seq #(.ADDR_W(AW), .PULSE_CYCLES(PW), .MAX_PASSES(MAXP)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_setup(cmd_setup), .cmd_program(cmd_program), .cmd_reset(cmd_reset),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_pulse(arr_pulse), .arr_rd(arr_rd), .arr_rdata(arr_rdata),
        .busy(busy), .fail(fail), .poll_data(poll_data)
    );

    always #10 clk = ~clk;

    // Array model: counts pulses and their widths, answers reads one clock later.
    always @(posedge clk) begin
        pulse_prev <= arr_pulse;
        if (arr_pulse && !pulse_prev) pulses_seen <= pulses_seen + 1;
        if (arr_pulse) run_len <= run_len + 1;
        else begin
            if (pulse_prev && run_len != PW) bad_width <= bad_width + 1;
            run_len <= 0;
        end
        if (arr_rd) arr_rdata <= (pulses_seen >= need) ? arr_wdata : (arr_wdata ^ 8'h5A);
    end

    function automatic int exp_passes(int k);
        return (k > MAXP) ? MAXP : k;
    endfunction

    function automatic int exp_latency(int k);
        return exp_passes(k) * (PW + 2);
    endfunction

    function automatic logic [7:0] exp_poll(logic [7:0] d, int k);
        return (k > MAXP) ? (d ^ 8'h5A) : d;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic strobe(int which);
        @(negedge clk);
        cmd_setup   = (which == 0);
        cmd_program = (which == 1);
        cmd_reset   = (which == 2);
        @(negedge clk);
        cmd_setup = 1'b0; cmd_program = 1'b0; cmd_reset = 1'b0;
    endtask

    // Runs one operation and checks its latency, pulses and final status.
    task automatic run_op(logic [AW-1:0] a, logic [7:0] d, int k, logic exp_fail,
                          bit poke_busy);
        int cyc;
        @(negedge clk);
        need = k; pulses_seen = 0; bad_width = 0;
        cmd_setup = 1'b1;
        @(negedge clk);
        cmd_setup = 1'b0; cmd_program = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_program = 1'b0;
        check("R1", "busy after setup+program", int'(busy), 1);
        check("R6", "poll while busy", int'(poll_data), int'({~d[7], 7'b0}));
        check("R2", "array address", int'(arr_addr), int'(a));
        cyc = 0;
        if (poke_busy) begin
            // R8: strobes while busy must not retarget or restart.
            cmd_setup = 1'b1; @(negedge clk); cyc++;
            cmd_setup = 1'b0; cmd_program = 1'b1; cmd_addr = ~a; cmd_data = ~d;
            @(negedge clk); cyc++;
            cmd_program = 1'b0; cmd_reset = 1'b1;
            @(negedge clk); cyc++;
            cmd_reset = 1'b0;
            check("R8", "target kept while busy", int'(arr_wdata), int'(d));
        end
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check("R4", "latency", cyc, exp_latency(k));
        check("R5", "pulse count", pulses_seen, exp_passes(k));
        check("R2", "pulse width errors", bad_width, 0);
        check("R7", "poll after end", int'(poll_data), int'(exp_poll(d, k)));
        check("R9", "fail flag", int'(fail), int'(exp_fail));
        @(negedge clk);
        check("R8", "no restart after op", int'(busy), 0);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "busy", int'(busy), 0);
        check("R10", "fail", int'(fail), 0);
        check("R10", "pulse", int'(arr_pulse), 0);
        check("R10", "read", int'(arr_rd), 0);
        check("R10", "poll", int'(poll_data), 8'hFF);

        // R1: program without set-up is ignored
        pulses_seen = 0;
        strobe(1);
        check("R1", "lone program", int'(busy), 0);
        // R1: set-up, reset, program is ignored
        strobe(0); strobe(2); strobe(1);
        check("R1", "broken pair", int'(busy), 0);
        check("R1", "no pulses", pulses_seen, 0);

        // R3/R4: single-pass success
        run_op(4'd3, 8'hA5, 1, 1'b0, 1'b0);
        // R4: success on the last allowed pass
        run_op(4'd9, 8'h3C, MAXP, 1'b0, 1'b0);
        // R5: exhaustion
        run_op(4'd0, 8'h81, MAXP + 1, 1'b1, 1'b0);
        // R9/R8: fail survives a passing op and a reset strobe while busy
        run_op(4'd5, 8'h12, 3, 1'b1, 1'b1);
        strobe(2);
        check("R9", "fail cleared by reset cmd", int'(fail), 0);
        // R8: busy pokes on a clean op
        run_op(4'd15, 8'hF0, 4, 1'b0, 1'b1);

        // Random operations
        for (int i = 0; i < 20; i++) begin
            logic [AW-1:0] a;
            logic [7:0]    d;
            int            k;
            a = AW'($urandom);
            d = 8'($urandom);
            k = 1 + int'($urandom % 6);
            run_op(a, d, k, 1'b0, 1'b0);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule